// File: doc/BRIEF.md
# BCD Seven-Segment Latching Decoder

The block turns a four-bit decimal digit code into seven active-high segment drives for a common-cathode display. A four-bit holding register sits in front of the decoder. While the hold input is low, the register loads the live code on every clock edge, and the outputs decode that live code in the same cycle. While the hold input is high, the register keeps the code it last loaded, and the outputs decode the kept code.

Two active-low overrides sit after the decoder. The lamp-test input turns every segment on. The blank input turns every segment off. Lamp test wins over blank, and blank wins over the decoded digit. Neither override changes the stored code. Codes 10 to 15 are not decimal digits and decode to a dark display. Segment bit order is {g,f,e,d,c,b,a}, with segment a in bit 0.

Top module: `seg7_latch_dec`

## Requirements
- R1: After a synchronous reset the stored code is 0. With hold high and both overrides inactive, the outputs show the pattern for 0 (7'h3F) whatever the input code is.
- R2: With hold low and both overrides inactive, the outputs decode the live input code in the same cycle, with no register delay.
- R3: With hold high, the outputs decode the code that was present at the last clock edge at which hold was low. Later changes of the input code have no effect.
- R4: Lamp test low (lamp_test_n=0) drives seg=7'h7F, whatever the blank, hold or code inputs are.
- R5: With lamp test high, blank low (blank_n=0) drives seg=7'h00, whatever the code or hold inputs are.
- R6: Digits 0 to 4 decode, in {g..a} order, to 0:3F, 1:06, 2:5B, 3:4F, 4:66.
- R7: Digits 5 to 9 decode to 5:6D, 6:7C (segment a off), 7:07, 8:7F, 9:67 (segment d off).
- R8: Codes 10 to 15 decode to seg=7'h00.
- R9: While hold is high, asserting and then releasing lamp test or blank leaves the stored code unchanged. When both overrides return high, the held digit reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the stored code to 0 |
| bcd_in | input | 4 | Digit code input |
| hold | input | 1 | 1 = keep the stored code; 0 = transparent, load every edge |
| blank_n | input | 1 | Active-low blank |
| lamp_test_n | input | 1 | Active-low lamp test |
| seg | output | 7 | Segment drives {g,f,e,d,c,b,a}, active high |

## Verification
Only the register has latency. Every segment result is combinational from the inputs and the stored code, so each result is due in the same cycle as its stimulus. The bench drives inputs just after the falling clock edge and samples a little later, still before the rising edge. For the held path, the bench records the code present at the last rising edge with hold low. It then checks the held digit in every later cycle in which hold stays high, including across override pulses and input changes. The bench's model of the stored code updates at each rising edge in the same way, so every comparison is made within the cycle in which the result is valid.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
    localparam int CODE_W = 4;
    localparam int SEG_W  = 7;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_W-1:0]  seg_t;

    typedef enum logic [1:0] {
        OVR_NONE  = 2'd0,
        OVR_BLANK = 2'd1,
        OVR_LAMP  = 2'd2
    } ovr_e;

    typedef struct packed {
        logic hold;
        logic blank_n;
        logic lamp_n;
    } ctrl_t;

    localparam seg_t SEG_ALL_ON  = '1;
    localparam seg_t SEG_ALL_OFF = '0;

    // Segment bit order {g,f,e,d,c,b,a}
    function automatic seg_t digit_pattern(code_t c);
        seg_t s;
        case (c)
            4'd0: s = 7'h3F;
            4'd1: s = 7'h06;
            4'd2: s = 7'h5B;
            4'd3: s = 7'h4F;
            4'd4: s = 7'h66;
            4'd5: s = 7'h6D;
            4'd6: s = 7'h7C;
            4'd7: s = 7'h07;
            4'd8: s = 7'h7F;
            4'd9: s = 7'h67;
            default: s = SEG_ALL_OFF;
        endcase
        return s;
    endfunction

    function automatic ovr_e pick_override(ctrl_t c);
        if (!c.lamp_n)       return OVR_LAMP;
        else if (!c.blank_n) return OVR_BLANK;
        else                 return OVR_NONE;
    endfunction
endpackage

// File: rtl/seg7_code_latch.sv
module seg7_code_latch
    import seg7_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  code_t code_in,
    output code_t code_eff
);
    code_t stored;

    always_ff @(posedge clk) begin
        if (rst)        stored <= '0;
        else if (!hold) stored <= code_in;
    end

    assign code_eff = hold ? stored : code_in;

    p_held_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold) && !$past(rst)) |-> $stable(code_eff));
    p_transparent_r2: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (stored == $past(code_in)));
endmodule

// File: rtl/seg7_decode.sv
module seg7_decode
    import seg7_pkg::*;
(
    input  code_t code,
    output seg_t  pattern
);
    localparam int NCODES = 1 << CODE_W;
    seg_t rom [NCODES];

    for (genvar i = 0; i < NCODES; i++) begin : g_rom
        assign rom[i] = digit_pattern(code_t'(i));
    end

    assign pattern = rom[code];

    always_comb begin
        if (code > 4'd9) p_illegal_dark_r8: assert (pattern == SEG_ALL_OFF);
    end
endmodule

// File: rtl/seg7_override.sv
module seg7_override
    import seg7_pkg::*;
(
    input  ctrl_t ctrl,
    input  seg_t  pattern,
    output seg_t  seg
);
    ovr_e sel;
    assign sel = pick_override(ctrl);

    always_comb begin
        unique case (sel)
            OVR_LAMP:  seg = SEG_ALL_ON;
            OVR_BLANK: seg = SEG_ALL_OFF;
            default:   seg = pattern;
        endcase
    end

    always_comb begin
        if (!ctrl.lamp_n) p_lamp_on_r4: assert (seg == SEG_ALL_ON);
        if (ctrl.lamp_n && !ctrl.blank_n) p_blank_off_r5: assert (seg == SEG_ALL_OFF);
    end
endmodule

// File: rtl/seg7_latch_dec.sv
module seg7_latch_dec
    import seg7_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bcd_in,
    input  logic       hold,
    input  logic       blank_n,
    input  logic       lamp_test_n,
    output logic [6:0] seg
);
    ctrl_t ctrl;
    code_t code_eff;
    seg_t  pattern;

    assign ctrl = '{hold: hold, blank_n: blank_n, lamp_n: lamp_test_n};

    seg7_code_latch u_latch (
        .clk(clk), .rst(rst), .hold(hold),
        .code_in(bcd_in), .code_eff(code_eff)
    );

    seg7_decode u_dec (.code(code_eff), .pattern(pattern));

    seg7_override u_ovr (.ctrl(ctrl), .pattern(pattern), .seg(seg));

    p_reset_zero_r1: assert property (@(posedge clk)
        (rst ##1 (hold && blank_n && lamp_test_n)) |-> (seg == 7'h3F));
    p_override_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold) && !$past(rst) && blank_n && lamp_test_n
         && $stable(bcd_in)) |-> $stable(seg) || !$past(blank_n && lamp_test_n));
endmodule

// File: tb/seg7_latch_dec_bench.sv
module seg7_latch_dec_bench;
    logic clk = 0;
    logic rst = 1;
    logic [3:0] bcd_in = 0;
    logic hold = 0, blank_n = 1, lamp_test_n = 1;
    logic [6:0] seg;
    int total = 0, bad = 0;
    logic [3:0] model_q = 0;

    always #2 clk = ~clk;

    seg7_latch_dec u_seg7_latch_dec (.*);

    function automatic logic [6:0] ref_digit(logic [3:0] c);
        logic [6:0] t;
        case (c)
            0: t = 7'b0111111; 1: t = 7'b0000110; 2: t = 7'b1011011;
            3: t = 7'b1001111; 4: t = 7'b1100110; 5: t = 7'b1101101;
            6: t = 7'b1111100; 7: t = 7'b0000111; 8: t = 7'b1111111;
            9: t = 7'b1100111; default: t = 7'b0;
        endcase
        return t;
    endfunction

    function automatic logic [6:0] ref_seg(logic [3:0] live, logic [3:0] q,
                                           logic h, logic b, logic l);
        if (!l) return 7'h7F;
        if (!b) return 7'h00;
        return ref_digit(h ? q : live);
    endfunction

    always @(posedge clk)
        if (rst) model_q <= 0;
        else if (!hold) model_q <= bcd_in;

    task automatic check(string req, logic [6:0] exp);
        total++;
        if (seg !== exp) begin
            bad++;
            $display("FAIL %s: seg=%h expected=%h", req, seg, exp);
        end
    endtask

    task automatic step(logic [3:0] c, logic h, logic b, logic l);
        @(negedge clk);
        bcd_in = c; hold = h; blank_n = b; lamp_test_n = l;
        #1;
    endtask

    task automatic chk_model(string req);
        check(req, ref_seg(bcd_in, model_q, hold, blank_n, lamp_test_n));
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: expected=done actual=hung");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        step(4'd7, 1, 1, 1);
        rst = 1;
        @(negedge clk); rst = 0; #1;
        check("R1", 7'h3F);
        step(4'd5, 1, 1, 1); check("R1", 7'h3F);
        // directed decode of every code, transparent
        for (int i = 0; i < 16; i++) begin
            step(4'(i), 0, 1, 1);
            if (i < 5) check("R6", ref_digit(4'(i)));
            else if (i < 10) check("R7", ref_digit(4'(i)));
            else check("R8", 7'h00);
            check("R2", ref_digit(4'(i)));
        end
        // full combination sweep
        for (int i = 0; i < 16; i++)
            for (int m = 0; m < 8; m++) begin
                step(4'(i), m[2], m[1], m[0]);
                if (!m[0]) check("R4", 7'h7F);
                else if (!m[1]) check("R5", 7'h00);
                else chk_model("R3");
            end
        // hold a 9, then wiggle inputs and overrides
        step(4'd9, 0, 1, 1);
        step(4'd2, 1, 1, 1); check("R3", 7'h67);
        step(4'd4, 1, 1, 1); check("R3", 7'h67);
        step(4'd1, 1, 0, 1); check("R5", 7'h00);
        step(4'd3, 1, 1, 0); check("R4", 7'h7F);
        step(4'd8, 1, 0, 0); check("R4", 7'h7F);
        step(4'd0, 1, 1, 1); check("R9", 7'h67);
        // hold a 6
        step(4'd6, 0, 1, 1); check("R7", 7'h7C);
        step(4'd12, 1, 1, 1); check("R3", 7'h7C);
        step(4'd12, 0, 1, 1); check("R8", 7'h00);
        // random
        for (int k = 0; k < 2000; k++) begin
            step(4'($urandom), 1'($urandom), ($urandom % 8) != 0, ($urandom % 8) != 0);
            chk_model("R3");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule